// File: doc/BRIEF.md
# Multiplexer Network Fitness Evaluator

This block scores a candidate circuit for a two-bit by two-bit multiplier. The candidate is a feed-forward network of up to 30 two-input multiplexer nodes. Its wiring, the kind of each node and the four output taps are held as an index-based genotype. Each node has three source indices: data-when-high, data-when-low and select. It also has a one-bit kind that can invert the data-when-low source. The genotype is written through a node write port and a tap write port. A pulse on `start` launches one evaluation.

The evaluation runs in two phases. The first is a backward trace from the four taps, which finds the nodes that the outputs depend on. The second walks all 16 values of the 4-bit input. For each value it computes every node in index order on one shared node evaluator. It then compares the four tapped signals with the bits of the product. The result is the number of matching bits, at most 64, together with the number of active nodes.

An optional mask forces chosen node outputs to 1. This models stuck-at-1 faults, so a search loop elsewhere can measure how gracefully a candidate degrades.

Top module: `mux_net_eval`

## Requirements
- R1: After reset, `busy`, `done`, `score` and `active_count` are all 0, and every stored node gene and tap index is 0.
- R2: Signal index i in 0..3 is bit i of the 4-bit input value v. Node slot s has signal index 4+s. The operands are X = v[1:0] and Y = v[3:2]. Tap j is compared with bit j of X*Y.
- R3: A node outputs its data-when-high source when its select source is 1. When the select source is 0 it outputs its data-when-low source if `node_inv` = 0, and the complement of that source if `node_inv` = 1.
- R4: A node source index at or above the node's own signal index (4+s) reads as 0. A tap index of 34 or more reads as 0.
- R5: `score` is the number of (input value, tap) pairs, over all 16 values and 4 taps, where the tapped signal equals the product bit. It never exceeds 64.
- R6: When bit s of `fault_mask` is 1 at the start, slot s outputs 1 for the whole evaluation, whatever its sources are. The mask is captured when the evaluation is accepted.
- R7: `active_count` is the number of node slots reachable backward from the four taps through legal source indices. A tap on a primary input or on an out-of-range index adds no node.
- R8: `done` is a one-cycle pulse that rises exactly 526 clock cycles after the edge that accepts `start`. `score` and `active_count` are valid while `done` is high.
- R9: While `busy` is high, `start`, node writes and tap writes are ignored. `busy` stays high through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| node_wr | input | 1 | Write one node gene |
| node_slot | input | 5 | Node slot to write (0..29) |
| node_a | input | 6 | Source index used when the select is 1 |
| node_b | input | 6 | Source index used when the select is 0 |
| node_c | input | 6 | Select source index |
| node_inv | input | 1 | Node kind: 1 complements the select-0 source |
| tap_wr | input | 1 | Write one output tap |
| tap_sel | input | 2 | Tap (product bit) to write |
| tap_src | input | 6 | Signal index driving that tap |
| fault_mask | input | 30 | Per-slot stuck-at-1 request, captured at start |
| start | input | 1 | Launch an evaluation when idle |
| busy | output | 1 | Evaluation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| score | output | 7 | Count of matching truth-table bits |
| active_count | output | 5 | Number of nodes the taps depend on |

## Verification
Two things can meet in one cycle. A new `start` or a genotype write can arrive while an evaluation is still reading the stored genes and the captured fault mask. The bench provokes this by pulsing `start` and rewriting slot 0 about a hundred cycles into a run. It judges the result on three points: a single `done` pulse at the latency of the first request, no second pulse afterwards, and an unchanged score on a later rerun. A stuck-at-1 fault is also placed on a node that a tap reads in the same vector where that node is evaluated, and the score must equal the count of ones in the product table.

// File: rtl/mne_pkg.sv
package mne_pkg;

    localparam int N_IN      = 4;
    localparam int N_OUT     = 4;
    localparam int MAX_NODES = 30;
    localparam int IDX_W     = 6;
    localparam int N_VEC     = 1 << N_IN;
    localparam int SIG_N     = N_IN + MAX_NODES;
    localparam int SLOT_W    = $clog2(MAX_NODES);
    localparam int TAP_W     = $clog2(N_OUT);
    localparam int VEC_W     = N_IN;
    localparam int SCORE_W   = $clog2(N_VEC * N_OUT + 1);
    localparam int CNT_W     = $clog2(MAX_NODES + 1);
    localparam int STEP_W    = $clog2(N_OUT + 1);

    typedef enum logic {
        KIND_PASS = 1'b0,
        KIND_FLIP = 1'b1
    } node_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0] src_hi;
        logic [IDX_W-1:0] src_lo;
        logic [IDX_W-1:0] src_sel;
        node_kind_e       kind;
    } node_gene_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TRACE,
        PH_EVAL,
        PH_TALLY,
        PH_DONE
    } phase_e;

    // Signal lookup with an exclusive upper bound; anything at or above it reads 0.
    function automatic logic sig_at(logic [SIG_N-1:0] vals, logic [IDX_W-1:0] idx, int lim);
        if (int'(idx) < lim) return vals[idx];
        return 1'b0;
    endfunction

    function automatic logic [N_OUT-1:0] ref_product(logic [N_IN-1:0] v);
        logic [N_OUT-1:0] x;
        logic [N_OUT-1:0] y;
        x = {2'b00, v[1:0]};
        y = {2'b00, v[3:2]};
        return x * y;
    endfunction

    function automatic logic [STEP_W-1:0] match_count(logic [N_OUT-1:0] got, logic [N_OUT-1:0] want);
        logic [STEP_W-1:0] n;
        n = '0;
        for (int j = 0; j < N_OUT; j++)
            n = n + {{(STEP_W-1){1'b0}}, ~(got[j] ^ want[j])};
        return n;
    endfunction

    function automatic logic [CNT_W-1:0] pop_nodes(logic [MAX_NODES-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int s = 0; s < MAX_NODES; s++)
            n = n + {{(CNT_W-1){1'b0}}, m[s]};
        return n;
    endfunction

endpackage

// File: rtl/mne_gene_store.sv
module mne_gene_store
    import mne_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            lock,
    input  logic                            node_wr,
    input  logic [SLOT_W-1:0]               node_slot,
    input  node_gene_t                      node_gene,
    input  logic                            tap_wr,
    input  logic [TAP_W-1:0]                tap_sel,
    input  logic [IDX_W-1:0]                tap_src,
    output node_gene_t [MAX_NODES-1:0]      genes,
    output logic [N_OUT-1:0][IDX_W-1:0]     taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            genes <= '0;
            taps  <= '0;
        end else if (!lock) begin
            if (node_wr && int'(node_slot) < MAX_NODES)
                genes[node_slot] <= node_gene;
            if (tap_wr)
                taps[tap_sel] <= tap_src;
        end
    end

    AST_GENES_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(genes) && $stable(taps)));  // R9

endmodule

// File: rtl/mne_node_eval.sv
module mne_node_eval
    import mne_pkg::*;
(
    input  node_gene_t          gene,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [SIG_N-1:0]    vals,
    input  logic                stuck,
    output logic                y
);

    int   lim;
    logic d_hi;
    logic d_lo;
    logic sel;

    always_comb begin
        lim  = N_IN + int'(slot);
        d_hi = sig_at(vals, gene.src_hi, lim);
        d_lo = sig_at(vals, gene.src_lo, lim);
        sel  = sig_at(vals, gene.src_sel, lim);
        if (stuck)
            y = 1'b1;
        else if (sel)
            y = d_hi;
        else
            y = (gene.kind == KIND_FLIP) ? ~d_lo : d_lo;
    end

endmodule

// File: rtl/mne_reach.sv
module mne_reach
    import mne_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            seed,
    input  logic                            step,
    input  logic [SLOT_W-1:0]               slot,
    input  node_gene_t                      gene,
    input  logic [N_OUT-1:0][IDX_W-1:0]     taps,
    output logic [MAX_NODES-1:0]            active
);

    logic [N_OUT-1:0][MAX_NODES-1:0] tap_hit;
    logic [MAX_NODES-1:0]            seed_m;
    logic [MAX_NODES-1:0]            mark_m;
    logic [2:0][IDX_W-1:0]           refs;

    // One one-hot (or empty) mask per tap.
    for (genvar j = 0; j < N_OUT; j++) begin : g_tap
        always_comb begin
            tap_hit[j] = '0;
            if (int'(taps[j]) >= N_IN && int'(taps[j]) < SIG_N)
                tap_hit[j][int'(taps[j]) - N_IN] = 1'b1;
        end
    end

    always_comb begin
        seed_m = '0;
        for (int j = 0; j < N_OUT; j++)
            seed_m = seed_m | tap_hit[j];
    end

    always_comb begin
        refs   = {gene.src_hi, gene.src_lo, gene.src_sel};
        mark_m = '0;
        for (int r = 0; r < 3; r++)
            if (int'(refs[r]) >= N_IN && int'(refs[r]) < N_IN + int'(slot))
                mark_m[int'(refs[r]) - N_IN] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (seed)
            active <= seed_m;
        else if (step && active[slot])
            active <= active | mark_m;
    end

    AST_TRACE_GROWS: assert property (@(posedge clk) disable iff (rst)
        step |=> ((active & $past(active)) == $past(active)));  // R7

endmodule

// File: rtl/mux_net_eval.sv
module mux_net_eval
    import mne_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    node_wr,
    input  logic [SLOT_W-1:0]       node_slot,
    input  logic [IDX_W-1:0]        node_a,
    input  logic [IDX_W-1:0]        node_b,
    input  logic [IDX_W-1:0]        node_c,
    input  logic                    node_inv,
    input  logic                    tap_wr,
    input  logic [TAP_W-1:0]        tap_sel,
    input  logic [IDX_W-1:0]        tap_src,
    input  logic [MAX_NODES-1:0]    fault_mask,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic [SCORE_W-1:0]      score,
    output logic [CNT_W-1:0]        active_count
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_NODES - 1);
    localparam logic [VEC_W-1:0]  LAST_VEC  = VEC_W'(N_VEC - 1);

    phase_e                         ph;
    logic [SLOT_W-1:0]              k;
    logic [VEC_W-1:0]               vec;
    logic [SIG_N-1:0]               vals;
    logic [MAX_NODES-1:0]           fault_q;
    logic [SCORE_W-1:0]             acc;

    node_gene_t [MAX_NODES-1:0]     genes;
    logic [N_OUT-1:0][IDX_W-1:0]    taps;
    logic [MAX_NODES-1:0]           active;
    node_gene_t                     wr_gene;
    node_gene_t                     cur_gene;
    logic                           node_y;
    logic [N_OUT-1:0]               tapped;
    logic [STEP_W-1:0]              hits;
    logic                           accept;

    assign busy   = (ph != PH_IDLE);
    assign done   = (ph == PH_DONE);
    assign accept = (ph == PH_IDLE) && start;

    always_comb begin
        wr_gene.src_hi  = node_a;
        wr_gene.src_lo  = node_b;
        wr_gene.src_sel = node_c;
        wr_gene.kind    = node_inv ? KIND_FLIP : KIND_PASS;
    end

    mne_gene_store u_store (
        .clk       (clk),
        .rst       (rst),
        .lock      (busy),
        .node_wr   (node_wr),
        .node_slot (node_slot),
        .node_gene (wr_gene),
        .tap_wr    (tap_wr),
        .tap_sel   (tap_sel),
        .tap_src   (tap_src),
        .genes     (genes),
        .taps      (taps)
    );

    assign cur_gene = genes[k];

    mne_node_eval u_node (
        .gene  (cur_gene),
        .slot  (k),
        .vals  (vals),
        .stuck (fault_q[k]),
        .y     (node_y)
    );

    mne_reach u_reach (
        .clk    (clk),
        .rst    (rst),
        .seed   (accept),
        .step   (ph == PH_TRACE),
        .slot   (k),
        .gene   (cur_gene),
        .taps   (taps),
        .active (active)
    );

    always_comb begin
        for (int j = 0; j < N_OUT; j++)
            tapped[j] = sig_at(vals, taps[j], SIG_N);
        hits = match_count(tapped, ref_product(vec));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph           <= PH_IDLE;
            k            <= '0;
            vec          <= '0;
            vals         <= '0;
            fault_q      <= '0;
            acc          <= '0;
            score        <= '0;
            active_count <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        fault_q <= fault_mask;
                        acc     <= '0;
                        vec     <= '0;
                        k       <= LAST_SLOT;
                        ph      <= PH_TRACE;
                    end
                end
                PH_TRACE: begin
                    if (k == '0) begin
                        vals[N_IN-1:0] <= '0;
                        ph             <= PH_EVAL;
                    end else begin
                        k <= k - 1'b1;
                    end
                end
                PH_EVAL: begin
                    vals[N_IN + int'(k)] <= node_y;
                    if (k == LAST_SLOT)
                        ph <= PH_TALLY;
                    else
                        k <= k + 1'b1;
                end
                PH_TALLY: begin
                    if (vec == LAST_VEC) begin
                        score        <= acc + SCORE_W'(hits);
                        active_count <= pop_nodes(active);
                        ph           <= PH_DONE;
                    end else begin
                        acc            <= acc + SCORE_W'(hits);
                        vec            <= vec + 1'b1;
                        vals[N_IN-1:0] <= vec + 1'b1;
                        k              <= '0;
                        ph             <= PH_EVAL;
                    end
                end
                PH_DONE: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R8
    AST_DONE_AFTER_TALLY: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(ph) == PH_TALLY));  // R8
    AST_SCORE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(score) <= N_VEC * N_OUT));  // R5
    AST_ACTIVE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(active_count) <= MAX_NODES));  // R7
    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fault_q));  // R6

endmodule

// File: tb/mux_net_eval_bench.sv
`timescale 1ns/1ps
module mux_net_eval_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        node_wr = 1'b0;
    logic [4:0]  node_slot = '0;
    logic [5:0]  node_a = '0;
    logic [5:0]  node_b = '0;
    logic [5:0]  node_c = '0;
    logic        node_inv = 1'b0;
    logic        tap_wr = 1'b0;
    logic [1:0]  tap_sel = '0;
    logic [5:0]  tap_src = '0;
    logic [29:0] fault_mask = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [6:0]  score;
    logic [4:0]  active_count;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    int got_score;
    int got_act;

    int sh_a [30];
    int sh_b [30];
    int sh_c [30];
    int sh_inv [30];
    int sh_tap [4];

    always #4 clk = ~clk;

    mux_net_eval u_mux_net_eval (
        .clk(clk), .rst(rst),
        .node_wr(node_wr), .node_slot(node_slot), .node_a(node_a), .node_b(node_b),
        .node_c(node_c), .node_inv(node_inv),
        .tap_wr(tap_wr), .tap_sel(tap_sel), .tap_src(tap_src),
        .fault_mask(fault_mask), .start(start),
        .busy(busy), .done(done), .score(score), .active_count(active_count)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog: actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model written from R2..R6.
    function automatic int model_score(input logic [29:0] fm);
        int total = 0;
        for (int v = 0; v < 16; v++) begin
            logic [33:0] sv;
            int p;
            sv = '0;
            sv[3:0] = v[3:0];
            for (int s = 0; s < 30; s++) begin
                logic pa, pb, pc;
                pa = (sh_a[s] < 4 + s) ? sv[sh_a[s]] : 1'b0;
                pb = (sh_b[s] < 4 + s) ? sv[sh_b[s]] : 1'b0;
                pc = (sh_c[s] < 4 + s) ? sv[sh_c[s]] : 1'b0;
                sv[4 + s] = fm[s] ? 1'b1 : (pc ? pa : (sh_inv[s] != 0 ? ~pb : pb));
            end
            p = (v % 4) * (v / 4);
            for (int j = 0; j < 4; j++) begin
                logic bt;
                bt = (sh_tap[j] < 34) ? sv[sh_tap[j]] : 1'b0;
                if (bt == ((p >> j) & 1)) total++;
            end
        end
        return total;
    endfunction

    // Reachability from R7.
    function automatic int model_active();
        logic [29:0] act = '0;
        for (int j = 0; j < 4; j++)
            if (sh_tap[j] >= 4 && sh_tap[j] < 34) act[sh_tap[j] - 4] = 1'b1;
        for (int s = 29; s >= 0; s--) begin
            if (act[s]) begin
                if (sh_a[s] >= 4 && sh_a[s] < 4 + s) act[sh_a[s] - 4] = 1'b1;
                if (sh_b[s] >= 4 && sh_b[s] < 4 + s) act[sh_b[s] - 4] = 1'b1;
                if (sh_c[s] >= 4 && sh_c[s] < 4 + s) act[sh_c[s] - 4] = 1'b1;
            end
        end
        return $countones(act);
    endfunction

    task automatic set_node(input int s, input int a, input int b, input int c, input int inv);
        @(negedge clk);
        node_wr = 1'b1; node_slot = s[4:0];
        node_a = a[5:0]; node_b = b[5:0]; node_c = c[5:0]; node_inv = inv[0];
        @(negedge clk);
        node_wr = 1'b0;
        sh_a[s] = a; sh_b[s] = b; sh_c[s] = c; sh_inv[s] = inv;
    endtask

    task automatic set_taps(input int t0, input int t1, input int t2, input int t3);
        int tv [4];
        tv = '{t0, t1, t2, t3};
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            tap_wr = 1'b1; tap_sel = j[1:0]; tap_src = tv[j][5:0];
            @(negedge clk);
            tap_wr = 1'b0;
            sh_tap[j] = tv[j];
        end
    endtask

    task automatic run_eval(input logic [29:0] fm);
        int n;
        @(negedge clk);
        fault_mask = fm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 latency", n, 526);
        got_score = int'(score);
        got_act   = int'(active_count);
        @(negedge clk);
        chk("R8 done single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 score after reset", int'(score), 0);
        chk("R1 active after reset", int'(active_count), 0);
    endtask

    task automatic t_reset_genotype();
        // All genes zero: every node follows input 0; all taps read input 0.
        run_eval('0);
        chk("R1 R5 reset genotype score", got_score, model_score('0));
        chk("R7 reset genotype active", got_act, 0);
    endtask

    task automatic t_input_taps();
        set_taps(0, 1, 2, 3);
        run_eval('0);
        chk("R2 primary input taps score", got_score, model_score('0));
        chk("R7 primary input taps active", got_act, 0);
    endtask

    task automatic t_out_of_range_taps();
        set_taps(63, 40, 34, 63);
        run_eval('0);
        chk("R4 out-of-range taps score", got_score, 50);
        chk("R4 out-of-range taps active", got_act, 0);
    endtask

    task automatic t_and_node();
        // slot 0: sel = x0, hi = y0 (index 2), lo = x0 -> x0 & y0 = product bit 0
        set_node(0, 2, 0, 0, 0);
        set_taps(4, 63, 63, 63);
        run_eval('0);
        chk("R3 R5 single AND node score", got_score, 54);
        chk("R7 single AND node active", got_act, 1);
    endtask

    task automatic t_self_reference();
        set_node(0, 4, 4, 4, 1);
        set_taps(4, 4, 4, 4);
        run_eval('0);
        chk("R4 R3 self ref inverted score", got_score, 14);
        set_node(0, 4, 4, 4, 0);
        run_eval('0);
        chk("R4 self ref plain score", got_score, 50);
    endtask

    task automatic t_faults();
        set_node(0, 2, 0, 0, 0);
        set_taps(4, 4, 4, 4);
        run_eval(30'h1);
        chk("R6 fault on tapped node score", got_score, 14);
        run_eval(30'h2);
        chk("R6 fault on unused node score", got_score, model_score(30'h0));
        run_eval('0);
        chk("R6 fault mask cleared score", got_score, model_score('0));
    endtask

    task automatic t_reach();
        set_node(0, 1, 3, 2, 0);
        set_node(2, 4, 1, 11, 1);   // 11 is forward (slot 7): not legal for slot 2
        set_node(5, 6, 0, 1, 0);
        set_node(7, 9, 2, 3, 0);
        set_node(10, 8, 9, 0, 1);
        set_taps(9, 63, 1, 6);
        run_eval('0);
        chk("R7 backward trace active", got_act, 3);
        chk("R7 backward trace model", got_act, model_active());
        chk("R5 traced network score", got_score, model_score('0));
        run_eval(30'h24);
        chk("R6 faults on traced nodes score", got_score, model_score(30'h24));
    endtask

    task automatic t_busy_collision();
        int n;
        int seen;
        set_node(0, 0, 0, 0, 1);
        set_taps(4, 4, 4, 4);
        @(negedge clk);
        fault_mask = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
            if (n == 100) begin
                start = 1'b1; node_wr = 1'b1; node_slot = 5'd0;
                node_a = 6'd4; node_b = 6'd4; node_c = 6'd4; node_inv = 1'b0;
                tap_wr = 1'b1; tap_sel = 2'd0; tap_src = 6'd63;
            end else begin
                start = 1'b0; node_wr = 1'b0; tap_wr = 1'b0;
            end
        end
        start = 1'b0; node_wr = 1'b0; tap_wr = 1'b0;
        chk("R9 latency unaffected by second start", n, 526);
        chk("R9 score during collision", int'(score), 14);
        seen = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R9 no second done", seen, 0);
        chk("R9 idle after collision", int'(busy), 0);
        run_eval('0);
        chk("R9 writes while busy ignored", got_score, 14);
    endtask

    initial begin
        for (int s = 0; s < 30; s++) begin
            sh_a[s] = 0; sh_b[s] = 0; sh_c[s] = 0; sh_inv[s] = 0;
        end
        for (int j = 0; j < 4; j++) sh_tap[j] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reset_genotype();
        t_input_taps();
        t_out_of_range_taps();
        t_and_node();
        t_self_reference();
        t_faults();
        t_reach();
        t_busy_collision();
        summary();
        $finish;
    end

endmodule